// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a 16-bit countdown timer reached through a small synchronous register bus. Software writes a start value, picks a clock divider and a wrap policy, and turns counting on. Each time the divided clock ticks, the count drops by one. When a tick arrives while the count is already zero, the counter underflows. In periodic mode it then starts again from the stored start value. In free-running mode it rolls over to all ones. Every underflow raises an interrupt line that stays high until software writes to a dedicated clear location.

Two small state machines drive the behaviour. The run machine has the states STOPPED and COUNTING. A control write with the enable bit set takes STOPPED to COUNTING, and a control write with the enable bit clear takes COUNTING back to STOPPED. The interrupt machine has the states QUIET and PENDING. An underflow takes QUIET to PENDING. A clear write takes PENDING back to QUIET, but only in a cycle with no underflow. A separate prescaler counts system-clock cycles while the run machine is in COUNTING and emits one tick per divider period.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset the interrupt output is low, the run machine is STOPPED, and the load, value and control locations all read zero.
- R2: Word slots are decoded from address bits 4:2, and bits 1:0 are ignored. Slot 0 (offset 0) is the start value, slot 1 (offset 4) is the live count, slot 2 (offset 8) is control, slot 3 (offset 12) is the clear location and slot 4 (offset 16) is reserved. Offsets 0x14 and above have no effect when written and read as zero. Read data appears on `rd_data` after the clock edge that samples the read request.
- R3: Control layout: bit 7 is enable, bit 6 is mode (1 = periodic, 0 = free-running) and bits 3:2 select the divider. All other control bits read as zero.
- R4: A write to offset 0 stores the start value and copies it into the live count at the same edge, and it restarts the prescaler. Writes to offset 4 are ignored.
- R5: While counting, the count drops by one per divider period. Divider select 0 gives one decrement every clock, 1 gives one every 16 clocks, and both 2 and 3 give one every 256 clocks. The first decrement lands one full period after the enabling write.
- R6: A tick with the count at zero is an underflow. In periodic mode the count reloads from the start value, and in free-running mode it becomes 0xFFFF.
- R7: An underflow sets the interrupt output at the same edge that updates the count. The output then stays high until a write to offset 12 lowers it.
- R8: When an underflow and a clear write fall in the same cycle, the interrupt stays high.
- R9: While STOPPED, the live count and the prescaler progress both hold. Counting resumes from the held prescaler position when the timer is re-enabled.
- R10: Reads of offset 12 and of the reserved offset 16 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Sticky underflow interrupt |

## Verification
A wrong count or a wrong reload shows up on the next read of offset 4, one cycle after the faulty edge. It also shifts the cycle in which `irq` rises, which the bench pins down exactly. A prescaler that is off by one, that resets while stopped, or that decodes a divider wrongly moves the first decrement by whole clock periods, so a read placed one cycle either side of the expected edge exposes it. A wrong interrupt state shows on `irq` at the edge after the underflow or the clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 5;
    localparam int SLOT_W = ADDR_W - 2;

    localparam logic [SLOT_W-1:0] SLOT_LOAD  = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_VALUE = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_CTRL  = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_CLEAR = 3'd3;

    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_MODE_BIT = 6;
    localparam int CTRL_PS_LO    = 2;

    typedef enum logic {
        RUN_STOPPED,
        RUN_COUNTING
    } run_state_t;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_PENDING
    } irq_state_t;

    typedef enum logic {
        MODE_FREE     = 1'b0,
        MODE_PERIODIC = 1'b1
    } wrap_mode_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic [CNT_W-1:0]    cnt_val,
    input  logic                running,
    output logic [CNT_W-1:0]    load_q,
    output wrap_mode_t          mode_q,
    output logic [1:0]          ps_sel_q,
    output logic                load_wr,
    output logic                ctrl_wr,
    output logic                clr_wr,
    output logic [CNT_W-1:0]    rd_data
);
    logic [SLOT_W-1:0] slot;
    logic              rd_req;
    logic [CNT_W-1:0]  rd_mux;

    assign slot    = bus_addr[ADDR_W-1:2];
    assign rd_req  = bus_req && !bus_we;
    assign load_wr = bus_req && bus_we && (slot == SLOT_LOAD);
    assign ctrl_wr = bus_req && bus_we && (slot == SLOT_CTRL);
    assign clr_wr  = bus_req && bus_we && (slot == SLOT_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q   <= '0;
            mode_q   <= MODE_FREE;
            ps_sel_q <= '0;
        end else begin
            if (load_wr) load_q <= wr_data;
            if (ctrl_wr) begin
                mode_q   <= wrap_mode_t'(wr_data[CTRL_MODE_BIT]);
                ps_sel_q <= wr_data[CTRL_PS_LO +: 2];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (slot)
            SLOT_LOAD:  rd_mux = load_q;
            SLOT_VALUE: rd_mux = cnt_val;
            SLOT_CTRL: begin
                rd_mux[CTRL_EN_BIT]          = running;
                rd_mux[CTRL_MODE_BIT]        = mode_q;
                rd_mux[CTRL_PS_LO +: 2]      = ps_sel_q;
            end
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_req) rd_data <= rd_mux;
    end

    assert_clear_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && slot == SLOT_CLEAR) |=> (rd_data == '0));
    assert_ctrl_spare_bits_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && slot == SLOT_CTRL) |=> (rd_data[5:4] == 2'b00 && rd_data[1:0] == 2'b00));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_STEP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] ps_sel,
    output logic       tick
);
    localparam int TICK_W = 2 * PS_STEP;
    localparam logic [TICK_W-1:0] LIM_MID = TICK_W'((1 << PS_STEP) - 1);
    localparam logic [TICK_W-1:0] LIM_TOP = '1;

    logic [TICK_W-1:0] tick_cnt;
    logic [TICK_W-1:0] limit;

    always_comb begin
        unique case (ps_sel)
            2'd0:    limit = '0;
            2'd1:    limit = LIM_MID;
            default: limit = LIM_TOP;
        endcase
    end

    assign tick = run && (tick_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) tick_cnt <= '0;
        else if (tick)      tick_cnt <= '0;
        else if (run)       tick_cnt <= tick_cnt + 1'b1;
    end

    assert_prescaler_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(tick_cnt));
    assert_prescaler_steps_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && !tick) |=> (tick_cnt == $past(tick_cnt) + 1'b1));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             en_bit,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_wdata,
    input  logic [CNT_W-1:0] load_q,
    input  wrap_mode_t       mode,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running,
    output logic             uf
);
    run_state_t state_q, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RUN_STOPPED;
        else     state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RUN_STOPPED:  if (ctrl_wr && en_bit)  state_nx = RUN_COUNTING;
            RUN_COUNTING: if (ctrl_wr && !en_bit) state_nx = RUN_STOPPED;
        endcase
    end

    always_comb begin
        running = (state_q == RUN_COUNTING);
        uf      = tick && (cnt_q == '0) && !load_wr;
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (load_wr) cnt_q <= load_wdata;
        else if (tick) begin
            if (cnt_q == '0) cnt_q <= (mode == MODE_PERIODIC) ? load_q : '1;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_count_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!running && !load_wr) |=> $stable(cnt_q));
    assert_load_copies_R4: assert property (@(posedge clk) disable iff (rst)
        load_wr |=> (cnt_q == $past(load_wdata)));
    assert_free_wraps_R6: assert property (@(posedge clk) disable iff (rst)
        (uf && mode == MODE_FREE) |=> (cnt_q == '1));
    assert_periodic_reloads_R6: assert property (@(posedge clk) disable iff (rst)
        (uf && mode == MODE_PERIODIC) |=> (cnt_q == load_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic uf,
    input  logic clr_wr,
    output logic irq
);
    irq_state_t state_q, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state_q <= IRQ_QUIET;
        else     state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            IRQ_QUIET:   if (uf)            state_nx = IRQ_PENDING;
            IRQ_PENDING: if (clr_wr && !uf) state_nx = IRQ_QUIET;
        endcase
    end

    always_comb irq = (state_q == IRQ_PENDING);

    assert_underflow_raises_R7: assert property (@(posedge clk) disable iff (rst)
        uf |=> irq);
    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_wr) |=> irq);
    assert_underflow_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (uf && clr_wr) |=> irq);
    assert_clear_lowers_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !uf) |=> !irq);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PS_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    logic [CNT_W-1:0] load_q, cnt_q;
    wrap_mode_t       mode_q;
    logic [1:0]       ps_sel_q;
    logic             load_wr, ctrl_wr, clr_wr;
    logic             running, tick, uf;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .wr_data(wr_data), .cnt_val(cnt_q),
        .running(running), .load_q(load_q), .mode_q(mode_q),
        .ps_sel_q(ps_sel_q), .load_wr(load_wr), .ctrl_wr(ctrl_wr),
        .clr_wr(clr_wr), .rd_data(rd_data)
    );

    tmr_prescaler #(.PS_STEP(PS_STEP)) u_ps (
        .clk(clk), .rst(rst), .run(running), .restart(load_wr),
        .ps_sel(ps_sel_q), .tick(tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .en_bit(wr_data[CTRL_EN_BIT]),
        .load_wr(load_wr), .load_wdata(wr_data), .load_q(load_q),
        .mode(mode_q), .tick(tick), .cnt_q(cnt_q), .running(running), .uf(uf)
    );

    tmr_irq u_irq (
        .clk(clk), .rst(rst), .uf(uf), .clr_wr(clr_wr), .irq(irq)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && !running));
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    tick_timer u_tick_timer (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; wr_data = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 irq", {15'b0, irq}, 16'h0);
        rd(5'd8, v); check("R1 ctrl", v, 16'h0);
        rd(5'd4, v); check("R1 value", v, 16'h0);
        rd(5'd0, v); check("R1 load", v, 16'h0);
    endtask

    task automatic t_decode();
        logic [15:0] v;
        wr(5'd8, 16'hFFFF);
        rd(5'd8, v); check("R3 ctrl layout", v, 16'h00CC);
        wr(5'd8, 16'h0000);
        wr(5'd1, 16'h1234);
        rd(5'd0, v); check("R2 low bits ignored", v, 16'h1234);
        rd(5'd4, v); check("R4 load copies", v, 16'h1234);
        wr(5'd4, 16'hBEEF);
        rd(5'd4, v); check("R4 value write ignored", v, 16'h1234);
        wr(5'd24, 16'h0055);
        rd(5'd0, v); check("R2 outside window write", v, 16'h1234);
        rd(5'd24, v); check("R2 outside window read", v, 16'h0);
        rd(5'd12, v); check("R10 clear reads zero", v, 16'h0);
        rd(5'd16, v); check("R10 reserved reads zero", v, 16'h0);
    endtask

    task automatic t_periodic();
        logic [15:0] v;
        wr(5'd0, 16'd5);
        wr(5'd8, 16'h00C0);
        repeat (5) @(negedge clk);
        check("R5 no early irq", {15'b0, irq}, 16'h0);
        @(negedge clk);
        check("R7 irq on underflow", {15'b0, irq}, 16'h1);
        rd(5'd4, v); check("R6 periodic reload", v, 16'd5);
        rd(5'd4, v); check("R5 div1 decrement", v, 16'd4);
        wr(5'd8, 16'h0000);
        repeat (10) @(negedge clk);
        check("R7 irq sticky", {15'b0, irq}, 16'h1);
        rd(5'd4, v); check("R9 count held", v, 16'd2);
        wr(5'd12, 16'h0000);
        check("R7 clear lowers", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_free();
        logic [15:0] v;
        wr(5'd0, 16'd2);
        wr(5'd8, 16'h0080);
        repeat (2) @(negedge clk);
        check("R7 free no early irq", {15'b0, irq}, 16'h0);
        @(negedge clk);
        check("R7 free irq", {15'b0, irq}, 16'h1);
        rd(5'd4, v); check("R6 free wrap", v, 16'hFFFF);
        wr(5'd8, 16'h0000);
        wr(5'd12, 16'h0000);
    endtask

    task automatic t_div16();
        logic [15:0] v;
        wr(5'd0, 16'd1);
        wr(5'd8, 16'h00C4);
        repeat (15) @(negedge clk);
        rd(5'd4, v); check("R5 div16 no early step", v, 16'd1);
        repeat (15) @(negedge clk);
        check("R5 div16 before underflow", {15'b0, irq}, 16'h0);
        @(negedge clk);
        check("R5 div16 underflow", {15'b0, irq}, 16'h1);
        wr(5'd8, 16'h0000);
        wr(5'd12, 16'h0000);
    endtask

    task automatic t_div256(input logic [15:0] ctrl, input string tag);
        wr(5'd0, 16'd0);
        wr(5'd8, ctrl);
        repeat (255) @(negedge clk);
        check({tag, " before underflow"}, {15'b0, irq}, 16'h0);
        @(negedge clk);
        check({tag, " underflow"}, {15'b0, irq}, 16'h1);
        wr(5'd8, 16'h0000);
        wr(5'd12, 16'h0000);
    endtask

    task automatic t_priority();
        wr(5'd0, 16'd0);
        wr(5'd8, 16'h00C0);
        @(negedge clk);
        check("R7 irq set", {15'b0, irq}, 16'h1);
        wr(5'd12, 16'h0000);
        check("R8 underflow beats clear", {15'b0, irq}, 16'h1);
        wr(5'd8, 16'h0000);
        wr(5'd12, 16'h0000);
        check("R7 clear after stop", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_hold_prescaler();
        logic [15:0] v;
        wr(5'd0, 16'd3);
        wr(5'd8, 16'h00C4);
        repeat (7) @(negedge clk);
        wr(5'd8, 16'h0000);
        repeat (50) @(negedge clk);
        wr(5'd8, 16'h00C4);
        repeat (7) @(negedge clk);
        rd(5'd4, v); check("R9 prescaler held", v, 16'd3);
        rd(5'd4, v); check("R9 resumes mid period", v, 16'd2);
        wr(5'd8, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_periodic();
        t_free();
        t_div16();
        t_div256(16'h00C8, "R5 div256 sel2");
        t_div256(16'h00CC, "R5 div256 sel3");
        t_priority();
        t_hold_prescaler();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule